// File: doc/BRIEF.md
# Latching User Permit Matrix

This block combines up to twenty user permit lines into one local beam permit. The users are arranged in three groups: those that act on beam 1 only, those that act on both beams, and those that act on beam 2 only. A build-time parameter picks which groups this controller answers to. Every user line is active low, so a broken or unconnected wire reads as a withdrawn permit. The safe-beam flag is also active low. While that flag is asserted, a fixed set of users, chosen by a parameter, is left out of the AND.

The permit is computed twice, by two independent matrix cores, one for each loop direction. Each core latches its permit false as soon as any counted user withdraws. The permit then stays false, even after every input recovers, until a rearm pulse arrives while all counted inputs are true. On the cycle a core's permit falls, that core records which counted inputs were false. The record is kept until an accepted rearm clears it.

Each loop permit drives its loop gating switch. An active-low chained output, low only while both loops permit, lets another controller take this result as one of its ordinary user inputs.

Top module: `permit_matrix`

## Requirements
- R1: Reset state: both loop permits are 0, the chained output `permit_n_o` is 1 and the fault record is all zeros.
- R2: User lines are active low: 0 means permit given and 1 means withdrawn. Raising any counted line while the permit is 1 drives the permit to 0.
- R3: The permit is the AND of all counted users. One counted line at 1 is enough to drop it.
- R4: Bit layout of `user_n_i` is [5:0] beam-1 group, [13:6] both-beam group and [19:14] beam-2 group. In the default beam-1 selection the beam-2 group is not counted and never affects the permit.
- R5: `safe_n_i` is active low. While it is 0, the users in the mask (default bits 4, 5, 10 and 11) are not counted. While it is 1, those users count like any other.
- R6: Once the permit has fallen it stays 0, even when every input recovers, until a rearm is accepted.
- R7: A rearm pulse (`rearm_i` high for one cycle) sets the permit to 1 only when every counted input is 0 in that cycle. Otherwise the rearm is ignored and the permit stays 0.
- R8: On the cycle the permit falls, `fault_o` records the counted inputs that were at 1 (bit = 1 means withdrawn). The record is held unchanged until an accepted rearm clears it to zero.
- R9: User and safe-flag inputs pass through two synchroniser flops. A change applied before a clock edge is seen on the permit after the third rising edge.
- R10: Loops A and B are computed by separate cores and always agree. `permit_n_o` is 0 only while both loop permits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| user_n_i | input | 20 | User permits, active low, grouped beam-1 / both / beam-2 |
| safe_n_i | input | 1 | Safe-beam flag, active low; enables masking |
| rearm_i | input | 1 | Rearm pulse, one cycle high |
| loop_a_o | output | 1 | Loop A permit, 1 = permit |
| loop_b_o | output | 1 | Loop B permit, 1 = permit |
| permit_n_o | output | 1 | Chained permit, active low |
| fault_o | output | 20 | First-fault record, 1 = input was withdrawn |

## Verification
The bench targets four weak points.

- It lets inputs recover after a fall and checks that the permit stays down. A design that only gates combinationally would come back up on its own.
- It fires rearm while a counted user is still withdrawn. A design that skipped the qualification would hand out a permit during a fault.
- It toggles the safe flag with masked and unmasked users withdrawn, and raises beam-2 lines. A wrong mask polarity or group decode would either drop the permit needlessly or ignore a real fault.
- It checks the permit on the exact cycle a change should arrive, and checks that the fault record does not move when later inputs change. An extra or missing synchroniser stage, or a record that keeps tracking the inputs, would show up there.

// File: rtl/permit_pkg.sv
package permit_pkg;
   // Which user groups a controller answers to
   typedef enum logic [1:0] {
      SEL_ALL   = 2'd0,
      SEL_BEAM1 = 2'd1,
      SEL_BEAM2 = 2'd2
   } beam_sel_e;

   localparam int MAX_USERS = 20;
endpackage

// File: rtl/permit_sync.sv
module permit_sync #(
   parameter int          W       = 21,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("permit_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pipe[s] <= RST_VAL;
         end else begin
            if (s == 0) pipe[s] <= d_i;
            else        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/permit_core.sv
module permit_core
   import permit_pkg::*;
#(
   parameter int        N_B1     = 6,
   parameter int        N_BOTH   = 8,
   parameter int        N_B2     = 6,
   parameter logic [N_B1+N_BOTH+N_B2-1:0] MASK_USERS = 'h00C30,
   parameter beam_sel_e BEAM_SEL = SEL_BEAM1
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic [N_B1+N_BOTH+N_B2-1:0]     usr_n_i,
   input  logic                            safe_n_i,
   input  logic                            rearm_i,
   output logic                            permit_o,
   output logic [N_B1+N_BOTH+N_B2-1:0]     snap_o
);
   localparam int N = N_B1 + N_BOTH + N_B2;

   logic [N-1:0] relevant, ignored, counted, bad;
   logic         all_ok;
   logic         permit_q;
   logic [N-1:0] snap_q;

   // Group relevance chosen at build time
   case (BEAM_SEL)
      SEL_BEAM1: begin : g_b1
         assign relevant = {{N_B2{1'b0}}, {(N_BOTH+N_B1){1'b1}}};
      end
      SEL_BEAM2: begin : g_b2
         assign relevant = {{(N_B2+N_BOTH){1'b1}}, {N_B1{1'b0}}};
      end
      default: begin : g_all
         assign relevant = '1;
      end
   endcase

   assign ignored = safe_n_i ? '0 : MASK_USERS;
   assign counted = relevant & ~ignored;
   assign bad     = usr_n_i & counted;
   assign all_ok  = (bad == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         permit_q <= 1'b0;
         snap_q   <= '0;
      end else if (permit_q && !all_ok) begin
         permit_q <= 1'b0;
         snap_q   <= bad;
      end else if (!permit_q && rearm_i && all_ok) begin
         permit_q <= 1'b1;
         snap_q   <= '0;
      end
   end

   assign permit_o = permit_q;
   assign snap_o   = snap_q;

   AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!permit_q && !rearm_i) |=> !permit_q); // R6
   AST_RISE_NEEDS_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(permit_q) |-> $past(rearm_i)); // R7
   AST_FALL_RECORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(permit_q) |-> (snap_q != '0)); // R8
   AST_RECORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!permit_q && !rearm_i) |=> $stable(snap_q)); // R8
   AST_RECORD_CLEAR_WHEN_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      permit_q |-> (snap_q == '0)); // R8
endmodule

// File: rtl/permit_matrix.sv
module permit_matrix
   import permit_pkg::*;
#(
   parameter int        N_B1        = 6,
   parameter int        N_BOTH      = 8,
   parameter int        N_B2        = 6,
   parameter int        SYNC_STAGES = 2,
   parameter logic [N_B1+N_BOTH+N_B2-1:0] MASK_USERS = 'h00C30,
   parameter beam_sel_e BEAM_SEL    = SEL_BEAM1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [N_B1+N_BOTH+N_B2-1:0] user_n_i,
   input  logic                        safe_n_i,
   input  logic                        rearm_i,
   output logic                        loop_a_o,
   output logic                        loop_b_o,
   output logic                        permit_n_o,
   output logic [N_B1+N_BOTH+N_B2-1:0] fault_o
);
   localparam int N  = N_B1 + N_BOTH + N_B2;
   localparam int SW = N + 1;

   if (N > MAX_USERS || N < 1) begin : g_bad_count
      $error("permit_matrix: user count out of range");
   end

   logic [SW-1:0] sync_q;
   logic [N-1:0]  usr_s, snap_a, snap_b;
   logic          safe_s, perm_a, perm_b;

   // Fail-safe reset: every line reads as withdrawn, flag not asserted
   permit_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({safe_n_i, user_n_i}),
      .q_o   (sync_q)
   );

   assign usr_s  = sync_q[N-1:0];
   assign safe_s = sync_q[N];

   permit_core #(.N_B1(N_B1), .N_BOTH(N_BOTH), .N_B2(N_B2),
                 .MASK_USERS(MASK_USERS), .BEAM_SEL(BEAM_SEL)) i_core_a (
      .clk_i(clk_i), .rst_ni(rst_ni), .usr_n_i(usr_s), .safe_n_i(safe_s),
      .rearm_i(rearm_i), .permit_o(perm_a), .snap_o(snap_a)
   );

   permit_core #(.N_B1(N_B1), .N_BOTH(N_BOTH), .N_B2(N_B2),
                 .MASK_USERS(MASK_USERS), .BEAM_SEL(BEAM_SEL)) i_core_b (
      .clk_i(clk_i), .rst_ni(rst_ni), .usr_n_i(usr_s), .safe_n_i(safe_s),
      .rearm_i(rearm_i), .permit_o(perm_b), .snap_o(snap_b)
   );

   assign loop_a_o   = perm_a;
   assign loop_b_o   = perm_b;
   assign permit_n_o = ~(perm_a & perm_b);
   assign fault_o    = snap_a | snap_b;

   AST_LOOPS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      perm_a == perm_b); // R10
   AST_RECORDS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snap_a == snap_b); // R10
endmodule

// File: tb/test_permit_matrix.sv
module test_permit_matrix;
   localparam int N = 20;
   localparam logic [N-1:0] MASK = 20'h00C30;
   localparam logic [N-1:0] REL  = 20'h03FFF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] user_n = '1;
   logic         safe_n = 1'b1;
   logic         rearm = 1'b0;
   logic         loop_a, loop_b, permit_n;
   logic [N-1:0] fault;

   int n_checks = 0;
   int n_fail   = 0;
   logic         exp_perm = 1'b0;
   logic [N-1:0] exp_snap = '0;

   always #10 clk = ~clk;

   permit_matrix i_permit_matrix (
      .clk_i(clk), .rst_ni(rst_n), .user_n_i(user_n), .safe_n_i(safe_n),
      .rearm_i(rearm), .loop_a_o(loop_a), .loop_b_o(loop_b),
      .permit_n_o(permit_n), .fault_o(fault)
   );

   function automatic logic [N-1:0] bad_of(logic [N-1:0] u, logic s);
      logic [N-1:0] counted;
      counted = REL & ~(s ? '0 : MASK);
      return u & counted;
   endfunction

   task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      check(req, {19'd0, loop_a}, {19'd0, exp_perm});
      check({req, "/R10 loop B"}, {19'd0, loop_b}, {19'd0, exp_perm});
      check({req, "/R10 chain"}, {19'd0, permit_n}, {19'd0, ~exp_perm});
      check({req, "/R8 record"}, fault, exp_snap);
   endtask

   // Apply inputs, let them cross the synchroniser, update the model
   task automatic apply(logic [N-1:0] u, logic s, string req);
      @(negedge clk);
      user_n = u;
      safe_n = s;
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (exp_perm && bad_of(u, s) != '0) begin
         exp_perm = 1'b0;
         exp_snap = bad_of(u, s);
      end
      check_all(req);
   endtask

   task automatic pulse_rearm(string req);
      @(negedge clk);
      rearm = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rearm = 1'b0;
      if (!exp_perm && bad_of(user_n, safe_n) == '0) begin
         exp_perm = 1'b1;
         exp_snap = '0;
      end
      check_all(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20061));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;

      // Everything fine but no rearm yet: stays down (R6/R1)
      apply('0, 1'b1, "R1 no rearm after reset");
      pulse_rearm("R7 first rearm");

      // Latency: one both-beam user withdraws (R9)
      @(negedge clk);
      user_n = 20'h00040;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R9 not yet at edge 2", {19'd0, loop_a}, 20'd1);
      @(posedge clk);
      @(negedge clk);
      exp_perm = 1'b0;
      exp_snap = 20'h00040;
      check_all("R9 R3 falls at edge 3");

      // Recover inputs: latch holds, record held (R6, R8)
      apply('0, 1'b1, "R6 latched after recovery");
      apply(20'h00001, 1'b1, "R8 record unchanged by later fault");
      pulse_rearm("R7 rearm ignored during fault");
      apply('0, 1'b1, "R6 still latched");
      pulse_rearm("R7 accepted rearm");

      // Beam-2 group ignored (R4)
      apply(20'hFC000, 1'b1, "R4 beam-2 users ignored");
      // Open line on beam-1 user reads as withdrawn (R2)
      apply(20'hFC020, 1'b1, "R2 open line drops permit");
      apply('0, 1'b1, "R2 recovered");
      pulse_rearm("R2 rearm");

      // Masking (R5)
      apply(20'h00C30, 1'b0, "R5 masked users ignored when safe");
      apply(20'h00C30, 1'b1, "R5 masked users count when flag drops");
      apply('0, 1'b0, "R5 clear");
      pulse_rearm("R5 rearm");
      apply(20'h00C38, 1'b0, "R5 unmasked user counts while safe");
      apply(20'h00C30, 1'b0, "R5 masked still held");
      pulse_rearm("R7 rearm with only masked faults while safe");

      // Random mix
      for (int i = 0; i < 300; i++) begin
         logic [N-1:0] u;
         logic         s;
         u = $urandom & $urandom & $urandom & $urandom;
         if ($urandom_range(0, 3) == 0) u = '0;
         s = $urandom_range(0, 1) == 1;
         apply(u, s, "R3 random");
         if ($urandom_range(0, 1) == 1) pulse_rearm("R7 random rearm");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule